// File: doc/BRIEF.md
# Memory Bit-Field Operation Unit

This unit performs one operation on a bit field of 1 to 32 bits held in big-endian, byte-addressed memory. The field is located by a byte base address plus a signed bit offset, so a field may start before the base byte. The unit turns the offset into a starting byte and a bit position within it. It then fetches every byte the field covers, which is between one and five bytes, over a byte-wide request/acknowledge port. For the operations that change the field, it then stores those same bytes back.

The operations are:
- unsigned and signed extraction;
- insertion of a source value;
- inversion, clearing and setting of the field;
- a search for the first one bit.

Each operation returns a 32-bit result and the N and Z flags. Decoding of instructions happens elsewhere. A caller pulses `start` with the operands. It then waits for the one-cycle `done` pulse, after which the result and the flags stay steady until the next accepted start.

Top module: `bitfield_unit`

## Requirements
- R1: The 5-bit length code gives the field width as ((code - 1) mod 32) + 1, so code 0 selects 32 bits and code 1 selects one bit.
- R2: The bit offset is a signed 32-bit value. The first byte is at base + floor(offset / 8). The starting bit is offset mod 8, taken as non-negative, counting from the most significant bit (bit 7) of that byte as position 0.
- R3: The unit reads floor((bitpos + width - 1) / 8) + 1 bytes at ascending addresses from the first byte, one byte per request. A request stays asserted, with its address and direction unchanged, until it is acknowledged.
- R4: Op code 0 returns the field zero-extended and op code 1 returns it sign-extended. Op code 7 behaves as op code 0. None of these write memory.
- R5: Op code 2 replaces the field with the low width bits of the source operand. Its result is the previous field contents, zero-extended. Its flags are taken from the source operand shifted so that its low width bits sit at the top of a 32-bit word.
- R6: Op code 3 inverts the field, op code 4 clears it and op code 5 sets it. The result is the previous field contents, zero-extended.
- R7: A modifying op (codes 2 to 5) writes the bytes only after all reads are done. The writes go to the same addresses in the same ascending order as the reads, and bits outside the field keep their values.
- R8: Op code 6 returns the offset plus the number of leading zeros in the field. If the field is zero it returns the offset plus the width. It does not write memory.
- R9: N is the top bit of the flag word and Z is set when the flag word is zero. The flag word is the previous field placed at the top of a 32-bit word, or for op code 2 the shifted source.
- R10: `done` pulses for exactly one cycle at the end of an operation. The result and flags hold until the next start. A start seen while an operation is in progress is ignored, and no memory request appears while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 3 | Operation code |
| base_addr | input | 32 | Byte base address |
| bit_offset | input | 32 | Signed bit offset from base |
| len_code | input | 5 | Field width code |
| src_data | input | 32 | Source value for insertion |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with ack |
| mem_ack | input | 1 | Request acknowledged |

## Verification
The bench aims at these cases:
- negative offsets that are not multiples of eight. A wrong floor would shift the field by a whole byte, so it would read and write the wrong addresses.
- 32-bit fields at starting bit 7, which need all five bytes. A window sized for four would lose the last seven bits.
- length code 0. Getting it wrong would give a zero-width field and a false Z.

The bench also checks every neighbouring bit of the modified bytes after insert, invert, clear and set, so a mask that is off by one shows up as a changed memory byte. It checks a search over an all-zero field, where a design returning offset + 32 instead of offset + width is caught.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int DATA_W    = 32;
  localparam int LEN_W     = $clog2(DATA_W);
  localparam int CNT_W     = LEN_W + 1;
  localparam int MAX_BYTES = DATA_W / 8 + 1;
  localparam int WIN_W     = MAX_BYTES * 8;
  localparam int IDX_W     = $clog2(MAX_BYTES);

  typedef enum logic [2:0] {
    OP_EXTU = 3'd0, OP_EXTS = 3'd1, OP_INS = 3'd2, OP_INV = 3'd3,
    OP_CLR  = 3'd4, OP_SET  = 3'd5, OP_FFO = 3'd6, OP_ALT = 3'd7
  } bf_op_e;

  // width code to width: 0 -> DATA_W
  function automatic logic [CNT_W-1:0] eff_len(input logic [LEN_W-1:0] code);
    logic [LEN_W-1:0] m1;
    m1 = code - 1'b1;
    return {1'b0, m1} + 1'b1;
  endfunction

  function automatic logic is_modify(input bf_op_e op);
    return (op == OP_INS) || (op == OP_INV) || (op == OP_CLR) || (op == OP_SET);
  endfunction

  // ones in the top 'len' bits of a word
  function automatic logic [DATA_W-1:0] top_mask(input logic [CNT_W-1:0] len);
    return ~({DATA_W{1'b1}} >> len);
  endfunction

  function automatic logic [CNT_W-1:0] lead_zeros(input logic [DATA_W-1:0] v);
    int n;
    logic seen;
    n = DATA_W;
    seen = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!seen && v[i]) begin
        n = DATA_W - 1 - i;
        seen = 1'b1;
      end
    end
    return CNT_W'(n);
  endfunction

  function automatic logic [7:0] window_byte(input logic [WIN_W-1:0] w,
                                             input logic [IDX_W-1:0] idx);
    logic [WIN_W-1:0] s;
    s = w >> (8 * (MAX_BYTES - 1 - int'(idx)));
    return s[7:0];
  endfunction
endpackage

// File: rtl/bfu_geom.sv
module bfu_geom
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic [LEN_W-1:0]  len_code,
  output logic [ADDR_W-1:0] first_addr,
  output logic [2:0]        bit_pos,
  output logic [CNT_W-1:0]  len,
  output logic [IDX_W-1:0]  last_idx
);
  logic [DATA_W-1:0] byte_step;
  logic [CNT_W-1:0]  span;

  always_comb begin
    byte_step  = DATA_W'($signed(offset) >>> 3);
    first_addr = base + ADDR_W'(byte_step);
    bit_pos    = offset[2:0];
    len        = eff_len(len_code);
    span       = CNT_W'(bit_pos) + len - 1'b1;
    last_idx   = IDX_W'(span >> 3);
  end
endmodule

// File: rtl/bfu_alu.sv
module bfu_alu
  import bfu_pkg::*;
(
  input  bf_op_e            op,
  input  logic [WIN_W-1:0]  win,
  input  logic [2:0]        bit_pos,
  input  logic [CNT_W-1:0]  len,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] src,
  output logic [WIN_W-1:0]  new_win,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z
);
  localparam int PAD_W = WIN_W - DATA_W;

  logic [WIN_W-1:0]  shifted, fmask_w, ins_w;
  logic [DATA_W-1:0] tmask, left_fld, ins_left, ufld, sfld, flag_word;
  logic [CNT_W-1:0]  rshift;

  always_comb begin
    tmask     = top_mask(len);
    rshift    = CNT_W'(DATA_W) - len;
    shifted   = win << bit_pos;
    left_fld  = shifted[WIN_W-1 -: DATA_W] & tmask;
    ufld      = left_fld >> rshift;
    sfld      = DATA_W'($signed(left_fld) >>> rshift);
    ins_left  = src << rshift;
    fmask_w   = {tmask, {PAD_W{1'b0}}} >> bit_pos;
    ins_w     = {ins_left, {PAD_W{1'b0}}} >> bit_pos;

    unique case (op)
      OP_INS:  new_win = (win & ~fmask_w) | (ins_w & fmask_w);
      OP_INV:  new_win = win ^ fmask_w;
      OP_CLR:  new_win = win & ~fmask_w;
      OP_SET:  new_win = win | fmask_w;
      default: new_win = win;
    endcase

    unique case (op)
      OP_EXTS: result = sfld;
      OP_FFO:  result = offset + ((left_fld == '0) ? DATA_W'(len)
                                                   : DATA_W'(lead_zeros(left_fld)));
      default: result = ufld;
    endcase

    flag_word = (op == OP_INS) ? ins_left : left_fld;
    flag_n    = flag_word[DATA_W-1];
    flag_z    = (flag_word == '0);
  end
endmodule

// File: rtl/bfu_seq.sv
module bfu_seq
  import bfu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             modify,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             accept,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [IDX_W-1:0] byte_idx,
  output logic [WIN_W-1:0] win
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} state_e;
  state_e state;

  logic last_byte;

  assign accept    = start && (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign mem_req   = (state == S_READ) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign last_byte = (byte_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      byte_idx <= '0;
      win      <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state    <= S_READ;
          byte_idx <= '0;
          win      <= '0;
        end
        S_READ: if (mem_ack) begin
          win <= win | ({mem_rdata, {(WIN_W-8){1'b0}}} >> (8 * int'(byte_idx)));
          if (last_byte) begin
            byte_idx <= '0;
            state    <= modify ? S_WRITE : S_DONE;
          end else begin
            byte_idx <= byte_idx + 1'b1;
          end
        end
        S_WRITE: if (mem_ack) begin
          if (last_byte) state <= S_DONE;
          else           byte_idx <= byte_idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DATA_W-1:0] bit_offset,
  input  logic [LEN_W-1:0]  len_code,
  input  logic [DATA_W-1:0] src_data,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  bf_op_e            op_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] off_q, src_q;
  logic [LEN_W-1:0]  code_q;

  logic [ADDR_W-1:0] first_addr;
  logic [2:0]        bit_pos;
  logic [CNT_W-1:0]  len;
  logic [IDX_W-1:0]  last_idx, byte_idx;
  logic [WIN_W-1:0]  win, new_win;
  logic              accept, busy, modify;

  assign modify = is_modify(op_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_EXTU;
      base_q <= '0;
      off_q  <= '0;
      src_q  <= '0;
      code_q <= '0;
    end else if (accept) begin
      op_q   <= bf_op_e'(op);
      base_q <= base_addr;
      off_q  <= bit_offset;
      src_q  <= src_data;
      code_q <= len_code;
    end
  end

  bfu_geom #(.ADDR_W(ADDR_W)) i_geom (
    .base(base_q), .offset(off_q), .len_code(code_q),
    .first_addr(first_addr), .bit_pos(bit_pos), .len(len), .last_idx(last_idx)
  );

  bfu_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .modify(modify),
    .last_idx(last_idx), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .accept(accept), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .byte_idx(byte_idx), .win(win)
  );

  bfu_alu i_alu (
    .op(op_q), .win(win), .bit_pos(bit_pos), .len(len), .offset(off_q),
    .src(src_q), .new_win(new_win), .result(result),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  assign mem_addr  = first_addr + ADDR_W'(byte_idx);
  assign mem_wdata = window_byte(new_win, byte_idx);
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic              modify,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [2:0]        op_code,
  input logic [31:0]       result,
  input logic              flag_z
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> modify);

  assert_write_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |=> !(mem_req && !mem_we));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_code == 3'd0) && flag_z |-> result == 32'd0);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind bitfield_unit bitfield_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .modify(modify),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .op_code(op_q), .result(result), .flag_z(flag_z)
);

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] base_addr = '0, bit_offset = '0, src_data = '0;
  logic [4:0]  len_code = '0;
  logic        done, flag_n, flag_z, mem_req, mem_we;
  logic [31:0] result, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  bitfield_unit i_bitfield_unit (.*);

  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];

  typedef struct {
    logic [31:0] res;
    logic        n;
    logic        z;
    int          acc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  int acc_cnt = 0, exp_first = 0, exp_nb = 1;
  logic [31:0] last_res;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // memory model: ack one cycle after a fresh request
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[5:0]];
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // access monitor: address order and direction (R3, R7)
  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      check(mem_addr == 32'(exp_first + (acc_cnt % exp_nb)), "R3",
            "access address", mem_addr, 32'(exp_first + (acc_cnt % exp_nb)));
      check(mem_we == (acc_cnt >= exp_nb), "R7", "reads before writes",
            32'(mem_we), 32'(acc_cnt >= exp_nb));
      acc_cnt++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        bit same;
        e = sb.pop_front();
        check(result == e.res, e.tag, "result", result, e.res);
        check(flag_n == e.n, "R9", {e.tag, " flag N"}, 32'(flag_n), 32'(e.n));
        check(flag_z == e.z, "R9", {e.tag, " flag Z"}, 32'(flag_z), 32'(e.z));
        check(acc_cnt == e.acc, "R3", {e.tag, " access count"}, 32'(acc_cnt), 32'(e.acc));
        same = 1'b1;
        for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) same = 1'b0;
        check(same, "R7", {e.tag, " memory image"}, 32'(same), 32'd1);
        last_res = e.res;
      end
    end
  end

  function automatic logic get_bit(input int p);
    logic [7:0] b;
    b = exp_mem[p >> 3];
    return b[7 - (p & 7)];
  endfunction

  task automatic run_op(input int opc, input int base, input int off, input int lc,
                        input logic [31:0] src, input string tag, input bit poke);
    int len, p0, nb, k;
    logic [31:0] fv, la, fw, res;
    bit modify;
    exp_t e;
    len = ((lc - 1) & 31) + 1;
    p0  = base * 8 + off;
    nb  = ((p0 + len - 1) >> 3) - (p0 >> 3) + 1;
    modify = (opc >= 2) && (opc <= 5);
    fv = '0;
    for (int i = 0; i < len; i++) fv = {fv[30:0], get_bit(p0 + i)};
    la = fv << (32 - len);
    case (opc)
      1: begin
        logic [63:0] ext;
        ext = {32'd0, fv};
        if (fv[len-1]) ext = ext | (64'hFFFF_FFFF_FFFF_FFFF << len);
        res = ext[31:0];
      end
      6: begin
        k = len;
        for (int i = len - 1; i >= 0; i--) if (get_bit(p0 + i)) k = i;
        res = 32'(off + k);
      end
      default: res = fv;
    endcase
    fw = (opc == 2) ? (src << (32 - len)) : la;
    if (modify) begin
      for (int i = 0; i < len; i++) begin
        int p;
        logic nbit;
        p = p0 + i;
        case (opc)
          2: nbit = src[len - 1 - i];
          3: nbit = ~get_bit(p);
          4: nbit = 1'b0;
          default: nbit = 1'b1;
        endcase
        exp_mem[p >> 3][7 - (p & 7)] = nbit;
      end
    end
    e.res = res; e.n = fw[31]; e.z = (fw == 0);
    e.acc = modify ? 2 * nb : nb; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    acc_cnt = 0; exp_first = p0 >> 3; exp_nb = nb;
    op = 3'(opc); base_addr = 32'(base); bit_offset = 32'(off);
    len_code = 5'(lc); src_data = src; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      op = 3'd5; base_addr = 32'd40; bit_offset = 32'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    check(result == last_res, "R10", {tag, " result held"}, result, last_res);
    check(!mem_req, "R10", {tag, " idle bus"}, 32'(mem_req), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    check(!done, "R10", "reset done", 32'(done), 32'd0);
    check(!mem_req, "R10", "reset request", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(0, 16, 3, 5, 32'h0, "R4 unsigned extract", 1'b0);
    run_op(1, 16, -5, 7, 32'h0, "R2 signed extract negative offset", 1'b0);
    run_op(0, 12, 7, 0, 32'h0, "R1 width 32 five bytes", 1'b0);
    run_op(1, 30, -13, 0, 32'h0, "R1 signed width 32", 1'b0);
    run_op(1, 18, 2, 1, 32'h0, "R4 signed one bit", 1'b0);
    run_op(2, 20, 4, 12, 32'h000A_BCDE, "R5 insert", 1'b0);
    run_op(2, 24, 5, 0, 32'h8123_4567, "R5 insert width 32", 1'b1);
    run_op(3, 28, -1, 3, 32'h0, "R6 invert", 1'b0);
    run_op(4, 8, 9, 20, 32'h0, "R6 clear", 1'b0);
    run_op(5, 34, 6, 1, 32'h0, "R6 set", 1'b0);
    run_op(4, 20, -20, 16, 32'h0, "R6 clear for search", 1'b0);
    run_op(6, 20, -20, 16, 32'h0, "R8 search zero field", 1'b0);
    run_op(6, 40, -3, 20, 32'h0, "R8 search nonzero", 1'b0);
    run_op(7, 44, 11, 9, 32'h0, "R4 op 7 as unsigned", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule